// File: doc/BRIEF.md
# Readout Sequencer Control Register Bank

This block is the software-visible control store for a front-end readout sequencer. A simple synchronous bus (address, write strobe, read strobe, 16-bit write and read data) reaches a small set of registers. Those registers are:

- an 8-bit data word, whose meaning depends on the selected operation;
- an 8-bit mode word;
- an 8-bit phase word;
- a read-only status word;
- a 12-bit calibration DAC word;
- sixteen 8-bit bias DAC words.

The contents of these registers are driven to the sequencer core as steady control levels.

The mode word carries a 3-bit operation code and several flags, and two of those flags act by themselves. The soft reset flag produces a single-cycle pulse to the core and then clears itself. The soft trigger flag stays set until the core signals that the triggered operation has completed. When the operation code selects direct access, the low five bits of the data word are passed straight to the front-end control lines.

Top module: `seq_reg_bank`

## Requirements
- R1: After reset, every register reads zero and every control output is zero.
- R2: The data word (offset 0x0000), the phase word (offset 0x0800) and the calibration word (offset 0x0100) can be written and read back. Reads return 8 significant bits for the data and phase words and 12 for the calibration word, with all upper bits zero. Each value appears on its output one cycle after the write.
- R3: The bias bank has 16 entries of 8 bits. Entry i sits at offset 0x0180 + 4*i, is read back at that offset, and drives bits [8*i+7:8*i] of `biasDac`.
- R4: The mode word is at offset 0x0040. Its bits [2:0] drive `opMode`, with these codes: 000 passive, 001 normal readout, 010 multiplexer reset, 011 channel select, 100 full calibration, 101 direct access, 110 flash readout, 111 clock increment. Bit 3 drives `calPulseEn`, bit 4 drives `testMode` and bit 7 drives `hwTrigEn`.
- R5: Writing mode bit 5 as 1 raises `softReset` for exactly one cycle, starting the cycle after the write. After that cycle, mode bit 5 reads back as 0.
- R6: Writing mode bit 6 as 1 sets `softTrigger`, and mode bit 6 reads back as 1, until a cycle in which `coreOpDone` is high. From the next cycle both read 0. A mode write in the same cycle as `coreOpDone` takes precedence.
- R7: While `opMode` is 101, `directPins` bits 0 to 4 carry data bits 0 to 4, in the order hold, shift-in, clock, multiplexer reset, DAC-on. For any other code, `directPins` is zero.
- R8: The status word at offset 0x0C00 reads `coreHoldInFlash` in bit 0 and `coreQuiet` in bit 1, with all other bits zero. Writes to the status word change nothing.
- R9: A read from an unmapped or misaligned address returns zero, and a write to one changes no register.
- R10: `busRdata` is zero whenever `busRd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 16 | Byte address |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, valid in the same cycle as busRd |
| coreOpDone | input | 1 | Pulse from the core when a triggered operation finishes |
| coreHoldInFlash | input | 1 | Core flag: hold seen during flash readout |
| coreQuiet | input | 1 | Core flag: quiet condition |
| opMode | output | 3 | Operation code |
| calPulseEn | output | 1 | Calibration pulse enable |
| testMode | output | 1 | Front end in test mode |
| softReset | output | 1 | One-cycle sequencer reset pulse |
| softTrigger | output | 1 | Pending software trigger |
| hwTrigEn | output | 1 | Hardware trigger unmasked |
| dataOut | output | 8 | Data word (hold time, channel number or direct bits) |
| phaseOut | output | 8 | Clock phase word |
| calDac | output | 12 | Calibration DAC word |
| biasDac | output | 128 | Sixteen bias DAC words, entry i in bits [8*i+7:8*i] |
| directPins | output | 5 | Direct front-end control lines |

## Verification
A corrupted register, or a write decoded to the wrong entry, shows up one cycle after the write, both on the matching control output and in the same-cycle read of that address. A self-clearing flag that fails to clear is visible on `softReset` or `softTrigger` in the cycle after its clearing condition. An address decode fault shows as nonzero data on an unmapped read, or as a change to a neighbouring register, once the bench reads it back.

// File: rtl/seq_reg_pkg.sv
package seq_reg_pkg;
  localparam int ADDR_W = 16;
  localparam int BUS_W  = 16;
  localparam int REG_W  = 8;
  localparam int CAL_W  = 12;
  localparam int BIAS_N = 16;
  localparam int IDX_W  = $clog2(BIAS_N);
  localparam int PIN_W  = 5;

  localparam logic [ADDR_W-1:0] A_DATA   = 16'h0000;
  localparam logic [ADDR_W-1:0] A_MODE   = 16'h0040;
  localparam logic [ADDR_W-1:0] A_CAL    = 16'h0100;
  localparam logic [ADDR_W-1:0] A_BIAS   = 16'h0180;
  localparam logic [ADDR_W-1:0] A_PHASE  = 16'h0800;
  localparam logic [ADDR_W-1:0] A_STATUS = 16'h0C00;

  localparam logic [2:0] OP_DIRECT = 3'b101;

  localparam int MB_RESET = 5;
  localparam int MB_TRIG  = 6;

  typedef enum logic [2:0] {
    RD_NONE, RD_DATA, RD_MODE, RD_PHASE, RD_STATUS, RD_CAL, RD_BIAS
  } rdSel_e;

  typedef struct packed {
    logic             wrData;
    logic             wrMode;
    logic             wrPhase;
    logic             wrCal;
    logic             wrBias;
    logic [IDX_W-1:0] biasIdx;
    rdSel_e           rdSel;
  } strobe_t;
endpackage

// File: rtl/seq_reg_ctrl.sv
module seq_reg_ctrl
  import seq_reg_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output strobe_t           strobe
);
  localparam logic [ADDR_W-1:0] BIAS_SPAN = ADDR_W'(4 * BIAS_N);

  logic [ADDR_W-1:0] biasOff;
  logic              biasHit;
  logic              unusedOff;

  assign biasOff   = busAddr - A_BIAS;
  assign biasHit   = (busAddr >= A_BIAS) && (biasOff < BIAS_SPAN) && (busAddr[1:0] == 2'b00);
  assign unusedOff = ^biasOff;

  always_comb begin
    strobe         = '0;
    strobe.rdSel   = RD_NONE;
    strobe.biasIdx = biasOff[2 +: IDX_W];
    if (busWr) begin
      strobe.wrData  = (busAddr == A_DATA);
      strobe.wrMode  = (busAddr == A_MODE);
      strobe.wrPhase = (busAddr == A_PHASE);
      strobe.wrCal   = (busAddr == A_CAL);
      strobe.wrBias  = biasHit;
    end
    if (busRd) begin
      if      (busAddr == A_DATA)   strobe.rdSel = RD_DATA;
      else if (busAddr == A_MODE)   strobe.rdSel = RD_MODE;
      else if (busAddr == A_PHASE)  strobe.rdSel = RD_PHASE;
      else if (busAddr == A_STATUS) strobe.rdSel = RD_STATUS;
      else if (busAddr == A_CAL)    strobe.rdSel = RD_CAL;
      else if (biasHit)             strobe.rdSel = RD_BIAS;
    end
  end
endmodule

// File: rtl/seq_reg_dpath.sv
module seq_reg_dpath
  import seq_reg_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strobe,
  input  logic [BUS_W-1:0]        busWdata,
  input  logic                    coreOpDone,
  input  logic                    coreHoldInFlash,
  input  logic                    coreQuiet,
  output logic [BUS_W-1:0]        busRdata,
  output logic [REG_W-1:0]        modeReg,
  output logic [REG_W-1:0]        dataReg,
  output logic [REG_W-1:0]        phaseReg,
  output logic [CAL_W-1:0]        calReg,
  output logic [BIAS_N*REG_W-1:0] biasFlat,
  output logic [PIN_W-1:0]        directPins
);
  logic [REG_W-1:0] biasMem [BIAS_N];
  logic             unusedHi;

  assign unusedHi = ^busWdata[BUS_W-1:CAL_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg  <= '0;
      phaseReg <= '0;
      calReg   <= '0;
      modeReg  <= '0;
    end else begin
      if (strobe.wrData)  dataReg  <= busWdata[REG_W-1:0];
      if (strobe.wrPhase) phaseReg <= busWdata[REG_W-1:0];
      if (strobe.wrCal)   calReg   <= busWdata[CAL_W-1:0];
      if (strobe.wrMode) begin
        modeReg <= busWdata[REG_W-1:0];
      end else begin
        modeReg[MB_RESET] <= 1'b0;
        if (coreOpDone) modeReg[MB_TRIG] <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < BIAS_N; i++) begin : g_bias
    always_ff @(posedge clk) begin
      if (!rstN)                                          biasMem[i] <= '0;
      else if (strobe.wrBias && strobe.biasIdx == IDX_W'(i)) biasMem[i] <= busWdata[REG_W-1:0];
    end
    assign biasFlat[i*REG_W +: REG_W] = biasMem[i];
  end

  assign directPins = (modeReg[2:0] == OP_DIRECT) ? dataReg[PIN_W-1:0] : '0;

  always_comb begin
    busRdata = '0;
    unique case (strobe.rdSel)
      RD_DATA:   busRdata = BUS_W'(dataReg);
      RD_MODE:   busRdata = BUS_W'(modeReg);
      RD_PHASE:  busRdata = BUS_W'(phaseReg);
      RD_STATUS: busRdata = BUS_W'({coreQuiet, coreHoldInFlash});
      RD_CAL:    busRdata = BUS_W'(calReg);
      RD_BIAS:   busRdata = BUS_W'(biasMem[strobe.biasIdx]);
      default:   busRdata = '0;
    endcase
  end
endmodule

// File: rtl/seq_reg_bank.sv
module seq_reg_bank
  import seq_reg_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic                    busWr,
  input  logic                    busRd,
  input  logic [BUS_W-1:0]        busWdata,
  output logic [BUS_W-1:0]        busRdata,
  input  logic                    coreOpDone,
  input  logic                    coreHoldInFlash,
  input  logic                    coreQuiet,
  output logic [2:0]              opMode,
  output logic                    calPulseEn,
  output logic                    testMode,
  output logic                    softReset,
  output logic                    softTrigger,
  output logic                    hwTrigEn,
  output logic [REG_W-1:0]        dataOut,
  output logic [REG_W-1:0]        phaseOut,
  output logic [CAL_W-1:0]        calDac,
  output logic [BIAS_N*REG_W-1:0] biasDac,
  output logic [PIN_W-1:0]        directPins
);
  strobe_t          strobe;
  logic [REG_W-1:0] modeReg;

  seq_reg_ctrl u_ctrl (
    .busAddr (busAddr),
    .busWr   (busWr),
    .busRd   (busRd),
    .strobe  (strobe)
  );

  seq_reg_dpath u_dpath (
    .clk             (clk),
    .rstN            (rstN),
    .strobe          (strobe),
    .busWdata        (busWdata),
    .coreOpDone      (coreOpDone),
    .coreHoldInFlash (coreHoldInFlash),
    .coreQuiet       (coreQuiet),
    .busRdata        (busRdata),
    .modeReg         (modeReg),
    .dataReg         (dataOut),
    .phaseReg        (phaseOut),
    .calReg          (calDac),
    .biasFlat        (biasDac),
    .directPins      (directPins)
  );

  assign opMode      = modeReg[2:0];
  assign calPulseEn  = modeReg[3];
  assign testMode    = modeReg[4];
  assign softReset   = modeReg[MB_RESET];
  assign softTrigger = modeReg[MB_TRIG];
  assign hwTrigEn    = modeReg[7];
endmodule

// File: rtl/seq_reg_bank_chk.sv
module seq_reg_bank_chk
  import seq_reg_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic              busRd,
  input logic [BUS_W-1:0]  busWdata,
  input logic [BUS_W-1:0]  busRdata,
  input logic              coreOpDone,
  input logic [2:0]        opMode,
  input logic              softReset,
  input logic              softTrigger,
  input logic [REG_W-1:0]  dataOut,
  input logic [PIN_W-1:0]  directPins
);
  logic modeWr;
  assign modeWr = busWr && (busAddr == A_MODE);

  // R5
  reset_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    softReset |=> !softReset);

  // R5
  reset_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(softReset) |-> $past(modeWr && busWdata[MB_RESET]));

  // R6
  trig_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (softTrigger && !coreOpDone && !modeWr) |=> softTrigger);

  // R6
  trig_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (coreOpDone && !modeWr) |=> !softTrigger);

  // R7
  direct_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opMode == OP_DIRECT) |-> (directPins == dataOut[PIN_W-1:0]));

  // R10
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |-> (busRdata == '0));
endmodule

bind seq_reg_bank seq_reg_bank_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busAddr     (busAddr),
  .busWr       (busWr),
  .busRd       (busRd),
  .busWdata    (busWdata),
  .busRdata    (busRdata),
  .coreOpDone  (coreOpDone),
  .opMode      (opMode),
  .softReset   (softReset),
  .softTrigger (softTrigger),
  .dataOut     (dataOut),
  .directPins  (directPins)
);

// File: tb/seq_reg_bank_bench.sv
module seq_reg_bank_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [15:0]  busAddr = '0;
  logic         busWr = 1'b0;
  logic         busRd = 1'b0;
  logic [15:0]  busWdata = '0;
  logic [15:0]  busRdata;
  logic         coreOpDone = 1'b0;
  logic         coreHoldInFlash = 1'b0;
  logic         coreQuiet = 1'b0;
  logic [2:0]   opMode;
  logic         calPulseEn, testMode, softReset, softTrigger, hwTrigEn;
  logic [7:0]   dataOut, phaseOut;
  logic [11:0]  calDac;
  logic [127:0] biasDac;
  logic [4:0]   directPins;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  seq_reg_bank u_seq_reg_bank (.*);

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    busRd = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R1 opMode", opMode, 0);
    check("R1 flags", {calPulseEn, testMode, softReset, softTrigger, hwTrigEn}, 0);
    check("R1 biasDac", biasDac, 0);
    check("R1 calDac", calDac, 0);
    rd(16'h0040, d); check("R1 mode read", d, 0);
    rd(16'h0000, d); check("R1 data read", d, 0);
  endtask

  task automatic t_plain();
    logic [15:0] d;
    wr(16'h0000, 16'hABCD); check("R2 dataOut", dataOut, 8'hCD);
    rd(16'h0000, d); check("R2 data read", d, 16'h00CD);
    wr(16'h0800, 16'h1234); check("R2 phaseOut", phaseOut, 8'h34);
    rd(16'h0800, d); check("R2 phase read", d, 16'h0034);
    wr(16'h0100, 16'hFEDC); check("R2 calDac", calDac, 12'hEDC);
    rd(16'h0100, d); check("R2 cal read", d, 16'h0EDC);
  endtask

  task automatic t_bias();
    logic [15:0]  d;
    logic [127:0] exp = '0;
    for (int i = 0; i < 16; i++) begin
      wr(16'h0180 + 16'(4 * i), 16'hA500 + 16'(8'h11 + i * 7));
      exp[i*8 +: 8] = 8'(8'h11 + i * 7);
    end
    check("R3 biasDac", biasDac, exp);
    for (int i = 0; i < 16; i++) begin
      rd(16'h0180 + 16'(4 * i), d);
      check("R3 bias read", d, {8'h00, exp[i*8 +: 8]});
    end
  endtask

  task automatic t_mode();
    wr(16'h0040, 16'h0099);
    check("R4 opMode", opMode, 3'b001);
    check("R4 calPulseEn", calPulseEn, 1);
    check("R4 testMode", testMode, 1);
    check("R4 hwTrigEn", hwTrigEn, 1);
    wr(16'h0040, 16'h0016);
    check("R4 opMode flash", opMode, 3'b110);
    check("R4 flags", {calPulseEn, testMode, hwTrigEn}, 3'b010);
  endtask

  task automatic t_softReset();
    logic [15:0] d;
    wr(16'h0040, 16'h0024);
    check("R5 pulse high", softReset, 1);
    @(negedge clk); check("R5 pulse low", softReset, 0);
    rd(16'h0040, d); check("R5 mode read", d, 16'h0004);
  endtask

  task automatic t_trigger();
    logic [15:0] d;
    wr(16'h0040, 16'h0043);
    check("R6 set", softTrigger, 1);
    repeat (3) @(negedge clk);
    rd(16'h0040, d); check("R6 pending read", d, 16'h0043);
    coreOpDone = 1'b1;
    @(negedge clk); coreOpDone = 1'b0;
    check("R6 cleared", softTrigger, 0);
    rd(16'h0040, d); check("R6 cleared read", d, 16'h0003);
    wr(16'h0040, 16'h0040);
    @(negedge clk);
    busAddr = 16'h0040; busWdata = 16'h0041; busWr = 1'b1; coreOpDone = 1'b1;
    @(negedge clk); busWr = 1'b0; coreOpDone = 1'b0;
    check("R6 write wins", softTrigger, 1);
    coreOpDone = 1'b1; @(negedge clk); coreOpDone = 1'b0;
  endtask

  task automatic t_direct();
    wr(16'h0000, 16'h00F5);
    wr(16'h0040, 16'h0001);
    check("R7 not direct", directPins, 0);
    wr(16'h0040, 16'h0005);
    check("R7 direct", directPins, 5'h15);
    wr(16'h0000, 16'h000A);
    check("R7 direct follow", directPins, 5'h0A);
    wr(16'h0040, 16'h0000);
  endtask

  task automatic t_status();
    logic [15:0] d;
    coreHoldInFlash = 1'b1; coreQuiet = 1'b0;
    rd(16'h0C00, d); check("R8 hold", d, 16'h0001);
    coreHoldInFlash = 1'b0; coreQuiet = 1'b1;
    rd(16'h0C00, d); check("R8 quiet", d, 16'h0002);
    wr(16'h0C00, 16'hFFFF);
    coreQuiet = 1'b0;
    rd(16'h0C00, d); check("R8 write ignored", d, 16'h0000);
    rd(16'h0000, d); check("R8 data untouched", d, 16'h000A);
  endtask

  task automatic t_unmapped();
    logic [15:0]  d;
    logic [127:0] b0 = biasDac;
    rd(16'h0004, d); check("R9 unmapped", d, 0);
    rd(16'h0181, d); check("R9 misaligned", d, 0);
    rd(16'h01C0, d); check("R9 past bias", d, 0);
    wr(16'h0182, 16'h00EE);
    wr(16'h01C0, 16'h00EE);
    wr(16'h0044, 16'h00EE);
    check("R9 bias untouched", biasDac, b0);
    check("R9 mode untouched", {softTrigger, opMode}, 4'b0000);
    check("R9 data untouched", dataOut, 8'h0A);
    busAddr = 16'h0000; #1;
    check("R10 idle read", busRdata, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_bias();
    t_mode();
    t_softReset();
    t_trigger();
    t_direct();
    t_status();
    t_unmapped();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule